// File: doc/BRIEF.md
# Domain-Checked Translation Buffer

This block is a small, fully associative translation cache. Each entry holds a virtual page number, an address-space identifier, a global flag, a 4-bit domain number, three page permission bits (read, write, execute) and a physical frame number. A lookup presents a virtual page, the current address-space identifier and an access type. One cycle later the block returns hit or miss, the physical frame, and an abort flag with a fault status.

Every hit goes through two checks. The first is a 32-bit domain mode register that holds a 2-bit mode for each of the 16 domains. A mode either denies all access, defers to the page bits, or grants full access. If the mode defers, the access type is then checked against the permission bits of the entry.

Entries are loaded by a fill port, which replaces slots in round-robin order. A flush can clear every entry, or only the entries that map one virtual page. The mode register can be written and read back, so that software can save and restore it across a context switch. Page walking and exception handling are done outside the block.

Top module: `dchk_tlb`

## Requirements
- R1: A lookup presented with `lk_valid` high produces `rsp_valid` high on the next clock, with exactly one of `rsp_hit` and `rsp_miss` set. When no lookup was presented, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_abort` are all low.
- R2: An entry matches when all three hold:
  - it is valid;
  - its virtual page equals `lk_vpn`;
  - its address-space identifier equals `lk_asid`, or its global flag is set.

  If several entries match, the lowest slot index wins.
- R3: On a hit, the mode field `dmode[2d+1:2d]` of the entry's domain `d` is read. Values 2'b00 and 2'b11 abort the access with `rsp_fault` = 2'b01 (domain fault) and `rsp_pfn` = 0.
- R4: On a hit whose domain mode is 2'b01, the access type is checked against the entry's page bits: `lk_acc` 2'b00 (read) or 2'b11 needs bit 0, 2'b01 (write) needs bit 1, and 2'b10 (execute) needs bit 2. A missing bit aborts with `rsp_fault` = 2'b10 (permission fault) and `rsp_pfn` = 0.
- R5: On a hit whose domain mode is 2'b10, the access is granted whatever the page bits are. `rsp_pfn` carries the frame, with `rsp_abort` low and `rsp_fault` = 2'b00.
- R6: A write through `dmode_we` is visible on `dmode_rdata` on the next clock. It governs every lookup presented from the next clock on.
- R7: On a miss, `rsp_abort` is low, `rsp_fault` is 2'b00 and `rsp_pfn` is 0.
- R8: Fills go to slots 0, 1, 2, … in turn and wrap after the last slot, so the 17th fill of a 16-entry buffer replaces the first. Flushes do not move the replacement pointer.
- R9: `flush_all` invalidates every entry for lookups presented from the next clock on.
- R10: `flush_va` invalidates every entry whose virtual page equals `flush_vpn`, whatever its address-space identifier or global flag. Other entries are kept.
- R11: After reset all entries are invalid, the mode register reads 0 and all response outputs are low.
- R12: A lookup presented in the same cycle as a fill, flush or mode write sees the state before that update. When a flush and a fill occur together, the flush acts first and then the fill writes its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 read |
| fill_valid | input | 1 | Load a new entry into the next round-robin slot |
| fill_vpn | input | VPN_W | Virtual page of the new entry |
| fill_asid | input | ASID_W | Address-space identifier of the new entry |
| fill_global | input | 1 | Entry matches in all address spaces |
| fill_dom | input | 4 | Domain number of the new entry |
| fill_perm | input | 3 | Page bits: bit 0 read, bit 1 write, bit 2 execute |
| fill_pfn | input | PFN_W | Physical frame of the new entry |
| flush_all | input | 1 | Invalidate all entries |
| flush_va | input | 1 | Invalidate entries mapping `flush_vpn` |
| flush_vpn | input | VPN_W | Virtual page to flush |
| dmode_we | input | 1 | Write the domain mode register |
| dmode_wdata | input | 32 | New domain mode value, 2 bits per domain |
| dmode_rdata | output | 32 | Current domain mode value |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed |
| rsp_abort | output | 1 | Access aborted |
| rsp_fault | output | 2 | 00 none, 01 domain fault, 10 permission fault |
| rsp_pfn | output | PFN_W | Physical frame, 0 unless the access is granted |

## Verification
The bench builds the block with its default parameters: 16 entries, 16 domains, 20-bit pages and frames, and 8-bit identifiers. With 16 slots, a run of 17 fills reaches the round-robin wrap, and all four modes of every domain can be reached from random mode words. The random stimulus draws pages from only 16 values and identifiers from only 4 values. This makes duplicate matches, global-versus-private collisions and page flushes that hit several entries at once common events, rather than rare ones.

// File: rtl/dchk_tlb_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the domain-checked translation buffer.
// Assumes 2-bit access types and 2-bit domain modes.
package dchk_tlb_pkg;
    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_DOMAIN = 2'b01,
        FLT_PERM   = 2'b10
    } fault_e;

    localparam logic [1:0] ACC_READ  = 2'b00;
    localparam logic [1:0] ACC_WRITE = 2'b01;
    localparam logic [1:0] ACC_EXEC  = 2'b10;

    localparam logic [1:0] DM_DENY  = 2'b00;
    localparam logic [1:0] DM_PAGE  = 2'b01;
    localparam logic [1:0] DM_FULL  = 2'b10;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;
endpackage

// File: rtl/dchk_tlb_cam.sv
`timescale 1ns/1ps
// Entry storage and associative match.
// Holds ENTRIES translation entries. It matches them combinationally against the
// lookup page and identifier, and returns the lowest matching slot.
// Assumes the caller picks the fill slot. Flushes apply before a fill
// in the same cycle.
module dchk_tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int DOM_W   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [DOM_W-1:0]  fill_dom,
    input  logic [2:0]        fill_perm,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              flush_all,
    input  logic              flush_va,
    input  logic [VPN_W-1:0]  flush_vpn,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              hit,
    output logic [DOM_W-1:0]  hit_dom,
    output logic [2:0]        hit_perm,
    output logic [PFN_W-1:0]  hit_pfn
);
    logic [ENTRIES-1:0] match;
    logic [DOM_W-1:0]   ent_dom  [ENTRIES];
    logic [2:0]         ent_perm [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
    logic [IDX_W-1:0]   sel;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic              vld_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [ASID_W-1:0] asid_q;
        logic              glb_q;
        logic [DOM_W-1:0]  dom_q;
        logic [2:0]        perm_q;
        logic [PFN_W-1:0]  pfn_q;
        logic              load;

        assign load = fill_valid && (fill_idx == IDX_W'(i));

        // Valid bit: cleared by reset and flushes, then set by a fill to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
            end else if (load) begin
                vld_q <= 1'b1;
            end else if (flush_all || (flush_va && vpn_q == flush_vpn)) begin
                vld_q <= 1'b0;
            end
        end

        // Entry payload: captured on a fill to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_q  <= '0;
                asid_q <= '0;
                glb_q  <= 1'b0;
                dom_q  <= '0;
                perm_q <= '0;
                pfn_q  <= '0;
            end else if (load) begin
                vpn_q  <= fill_vpn;
                asid_q <= fill_asid;
                glb_q  <= fill_global;
                dom_q  <= fill_dom;
                perm_q <= fill_perm;
                pfn_q  <= fill_pfn;
            end
        end

        assign match[i]    = vld_q && (vpn_q == lk_vpn) && (glb_q || asid_q == lk_asid);
        assign ent_dom[i]  = dom_q;
        assign ent_perm[i] = perm_q;
        assign ent_pfn[i]  = pfn_q;
    end

    // Priority pick: the lowest matching slot wins.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel = IDX_W'(i);
        end
    end

    assign hit      = |match;
    assign hit_dom  = ent_dom[sel];
    assign hit_perm = ent_perm[sel];
    assign hit_pfn  = ent_pfn[sel];
endmodule

// File: rtl/dchk_tlb_victim.sv
`timescale 1ns/1ps
// Round-robin replacement pointer.
// Advances once per fill and wraps after the last slot. Flushes do not touch it.
module dchk_tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int LAST   = ENTRIES - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_valid,
    output logic [IDX_W-1:0] victim
);
    // Pointer update: step on each fill, wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim <= '0;
        end else if (fill_valid) begin
            victim <= (victim == IDX_W'(LAST)) ? '0 : victim + 1'b1;
        end
    end
endmodule

// File: rtl/dchk_tlb_check.sv
`timescale 1ns/1ps
// Two-level access check for a hit entry.
// First the 2-bit mode of the entry's domain, then, for the defer mode, the page bits.
// Purely combinational. Assumes the mode vector packs domain d at bits [2d+1:2d].
module dchk_tlb_check
    import dchk_tlb_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int MODE_W = 2 * NUM_DOM
) (
    input  logic [MODE_W-1:0] mode_vec,
    input  logic [DOM_W-1:0]  dom,
    input  logic [2:0]        perm,
    input  logic [1:0]        acc,
    output logic              abort,
    output logic [1:0]        fault
);
    logic [1:0] mode;
    logic       page_ok;

    assign mode = mode_vec[{dom, 1'b0} +: 2];

    // Page-bit selection by access type; code 11 is checked as a read.
    always_comb begin
        case (acc)
            ACC_WRITE: page_ok = perm[PERM_W];
            ACC_EXEC:  page_ok = perm[PERM_X];
            default:   page_ok = perm[PERM_R];
        endcase
    end

    // Domain mode decision: full grant, defer to page bits, or deny.
    always_comb begin
        case (mode)
            DM_FULL: begin
                abort = 1'b0;
                fault = FLT_NONE;
            end
            DM_PAGE: begin
                abort = !page_ok;
                fault = page_ok ? FLT_NONE : FLT_PERM;
            end
            default: begin
                abort = 1'b1;
                fault = FLT_DOMAIN;
            end
        endcase
    end
endmodule

// File: rtl/dchk_tlb.sv
`timescale 1ns/1ps
// Domain-checked translation buffer, top level.
// A lookup is answered one cycle later with hit/miss, frame, abort and fault status.
// The lookup uses the entry and mode state from before the same clock edge's updates.
// Assumes at most one fill per cycle. Page walking and fault handling are done elsewhere.
module dchk_tlb
    import dchk_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int NUM_DOM = 16,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int MODE_W = 2 * NUM_DOM,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [DOM_W-1:0]  fill_dom,
    input  logic [2:0]        fill_perm,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              flush_all,
    input  logic              flush_va,
    input  logic [VPN_W-1:0]  flush_vpn,
    input  logic              dmode_we,
    input  logic [MODE_W-1:0] dmode_wdata,
    output logic [MODE_W-1:0] dmode_rdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_abort,
    output logic [1:0]        rsp_fault,
    output logic [PFN_W-1:0]  rsp_pfn
);
    logic [MODE_W-1:0] dmode_q;
    logic [IDX_W-1:0]  victim;
    logic              cam_hit;
    logic [DOM_W-1:0]  cam_dom;
    logic [2:0]        cam_perm;
    logic [PFN_W-1:0]  cam_pfn;
    logic              chk_abort;
    logic [1:0]        chk_fault;
    logic              granted;

    dchk_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .victim(victim)
    );

    dchk_tlb_cam #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .DOM_W(DOM_W)
    ) u_cam (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_idx(victim), .fill_vpn(fill_vpn),
        .fill_asid(fill_asid), .fill_global(fill_global), .fill_dom(fill_dom),
        .fill_perm(fill_perm), .fill_pfn(fill_pfn),
        .flush_all(flush_all), .flush_va(flush_va), .flush_vpn(flush_vpn),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .hit(cam_hit), .hit_dom(cam_dom), .hit_perm(cam_perm), .hit_pfn(cam_pfn)
    );

    dchk_tlb_check #(.NUM_DOM(NUM_DOM)) u_check (
        .mode_vec(dmode_q), .dom(cam_dom), .perm(cam_perm), .acc(lk_acc),
        .abort(chk_abort), .fault(chk_fault)
    );

    // Domain mode register: saved and restored through the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmode_q <= '0;
        end else if (dmode_we) begin
            dmode_q <= dmode_wdata;
        end
    end

    assign dmode_rdata = dmode_q;
    assign granted     = lk_valid && cam_hit && !chk_abort;

    // Response register: one-cycle lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_abort <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_pfn   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && cam_hit;
            rsp_miss  <= lk_valid && !cam_hit;
            rsp_abort <= lk_valid && cam_hit && chk_abort;
            rsp_fault <= (lk_valid && cam_hit) ? chk_fault : FLT_NONE;
            rsp_pfn   <= granted ? cam_pfn : '0;
        end
    end
endmodule

// File: rtl/dchk_tlb_chk.sv
`timescale 1ns/1ps
// Property checker for the domain-checked translation buffer. It sees only the top-level ports.
module dchk_tlb_chk #(
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int NUM_DOM = 16,
    localparam int MODE_W = 2 * NUM_DOM
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              fill_valid,
    input logic              flush_all,
    input logic              dmode_we,
    input logic [MODE_W-1:0] dmode_wdata,
    input logic [MODE_W-1:0] dmode_rdata,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic              rsp_abort,
    input logic [1:0]        rsp_fault,
    input logic [PFN_W-1:0]  rsp_pfn
);
    a_r1_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid && (rsp_hit != rsp_miss));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_abort);

    a_r3_all_denied: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && dmode_rdata == '0 |=>
            (!rsp_hit || (rsp_abort && rsp_fault == 2'b01 && rsp_pfn == '0)));

    a_r5_all_full: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && dmode_rdata == {NUM_DOM{2'b10}} |=> !rsp_abort && rsp_fault == 2'b00);

    a_r6_mode_readback: assert property (@(posedge clk) disable iff (!rst_n)
        dmode_we |=> dmode_rdata == $past(dmode_wdata));

    a_r7_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> !rsp_abort && rsp_fault == 2'b00 && rsp_pfn == '0);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all && !fill_valid ##1 lk_valid |=> rsp_miss);

    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && !rsp_abort && dmode_rdata == '0);
endmodule

bind dchk_tlb dchk_tlb_chk #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .NUM_DOM(NUM_DOM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .fill_valid(fill_valid),
    .flush_all(flush_all), .dmode_we(dmode_we), .dmode_wdata(dmode_wdata),
    .dmode_rdata(dmode_rdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_abort(rsp_abort), .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn)
);

// File: tb/test_dchk_tlb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random operations,
// compared with a behavioural model built from the requirements.
module test_dchk_tlb;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, fill_valid = 0, fill_global = 0;
    logic        flush_all = 0, flush_va = 0, dmode_we = 0;
    logic [19:0] lk_vpn = 0, fill_vpn = 0, flush_vpn = 0, fill_pfn = 0;
    logic [7:0]  lk_asid = 0, fill_asid = 0;
    logic [1:0]  lk_acc = 0;
    logic [3:0]  fill_dom = 0;
    logic [2:0]  fill_perm = 0;
    logic [31:0] dmode_wdata = 0;
    logic [31:0] dmode_rdata;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_abort;
    logic [1:0]  rsp_fault;
    logic [19:0] rsp_pfn;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Model state.
    bit          m_v [N];
    logic [19:0] m_vpn [N], m_pfn [N];
    logic [7:0]  m_asid [N];
    bit          m_g [N];
    logic [3:0]  m_dom [N];
    logic [2:0]  m_perm [N];
    int          m_ptr = 0;
    logic [31:0] m_mode = 0;

    always #2.5 clk = ~clk;

    dchk_tlb i_dchk_tlb (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_acc(lk_acc), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_global(fill_global), .fill_dom(fill_dom), .fill_perm(fill_perm),
        .fill_pfn(fill_pfn), .flush_all(flush_all), .flush_va(flush_va),
        .flush_vpn(flush_vpn), .dmode_we(dmode_we), .dmode_wdata(dmode_wdata),
        .dmode_rdata(dmode_rdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_abort(rsp_abort), .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected lookup result from the requirements (R2..R5, R7).
    task automatic m_lookup(input logic [19:0] v, input logic [7:0] a, input logic [1:0] acc,
                            output bit eh, output bit ea, output logic [1:0] ef,
                            output logic [19:0] ep);
        int idx = -1;
        logic [1:0] md;
        bit need;
        for (int i = N - 1; i >= 0; i--)
            if (m_v[i] && m_vpn[i] == v && (m_g[i] || m_asid[i] == a)) idx = i;
        eh = (idx >= 0); ea = 0; ef = 2'b00; ep = '0;
        if (eh) begin
            md = m_mode[2*m_dom[idx] +: 2];
            need = (acc == 2'b01) ? m_perm[idx][1] : (acc == 2'b10) ? m_perm[idx][2] : m_perm[idx][0];
            if (md == 2'b00 || md == 2'b11) begin ea = 1; ef = 2'b01; end
            else if (md == 2'b01 && !need) begin ea = 1; ef = 2'b10; end
            else ep = m_pfn[idx];
        end
    endtask

    task automatic m_apply_flush(input bit all, input bit va, input logic [19:0] fv);
        for (int i = 0; i < N; i++)
            if (all || (va && m_vpn[i] == fv)) m_v[i] = 0;
    endtask

    task automatic m_apply_fill(input logic [19:0] v, input logic [7:0] a, input bit g,
                                input logic [3:0] d, input logic [2:0] p, input logic [19:0] f);
        m_v[m_ptr] = 1; m_vpn[m_ptr] = v; m_asid[m_ptr] = a; m_g[m_ptr] = g;
        m_dom[m_ptr] = d; m_perm[m_ptr] = p; m_pfn[m_ptr] = f;
        m_ptr = (m_ptr + 1) % N;
    endtask

    task automatic check_rsp(input string req, input bit eh, input bit ea,
                             input logic [1:0] ef, input logic [19:0] ep);
        chk(req, "hit", {rsp_valid, rsp_hit, rsp_miss}, {1'b1, eh, !eh});
        chk(req, "abort", rsp_abort, ea);
        chk(req, "fault", rsp_fault, ef);
        chk(req, "pfn", rsp_pfn, ep);
    endtask

    // One lookup; called at a negedge, returns at the next negedge with the result checked.
    task automatic do_lookup(input logic [19:0] v, input logic [7:0] a, input logic [1:0] acc,
                             input string req);
        bit eh, ea; logic [1:0] ef; logic [19:0] ep;
        lk_valid = 1; lk_vpn = v; lk_asid = a; lk_acc = acc;
        m_lookup(v, a, acc, eh, ea, ef, ep);
        @(negedge clk);
        lk_valid = 0;
        check_rsp(req, eh, ea, ef, ep);
    endtask

    task automatic do_fill(input logic [19:0] v, input logic [7:0] a, input bit g,
                           input logic [3:0] d, input logic [2:0] p, input logic [19:0] f);
        fill_valid = 1; fill_vpn = v; fill_asid = a; fill_global = g;
        fill_dom = d; fill_perm = p; fill_pfn = f;
        m_apply_fill(v, a, g, d, p, f);
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic do_flush(input bit all, input bit va, input logic [19:0] fv);
        flush_all = all; flush_va = va; flush_vpn = fv;
        m_apply_flush(all, va, fv);
        @(negedge clk);
        flush_all = 0; flush_va = 0;
    endtask

    task automatic do_mode(input logic [31:0] w);
        dmode_we = 1; dmode_wdata = w; m_mode = w;
        @(negedge clk);
        dmode_we = 0;
        chk("R6", "mode readback", dmode_rdata, w);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "rsp after reset", {rsp_valid, rsp_hit, rsp_miss, rsp_abort}, 4'b0);
        chk("R11", "mode after reset", dmode_rdata, 32'h0);
        do_lookup(20'h1, 8'h1, 2'b00, "R11 R7 empty");

        // Modes: dom0 page, dom1 full, dom2 deny, dom3 code 11, rest page.
        do_mode(32'h5555_55C9);

        do_fill(20'h1, 8'h1, 0, 4'd0, 3'b001, 20'hA0001);
        do_fill(20'h2, 8'h7, 1, 4'd1, 3'b000, 20'hA0002);
        do_fill(20'h3, 8'h1, 0, 4'd2, 3'b111, 20'hA0003);
        do_fill(20'h4, 8'h1, 0, 4'd3, 3'b111, 20'hA0004);
        do_fill(20'h5, 8'h1, 0, 4'd0, 3'b110, 20'hA0005);
        do_lookup(20'h1, 8'h2, 2'b00, "R2 asid mismatch");
        chk("R2", "asid mismatch misses", rsp_miss, 1'b1);
        do_lookup(20'h1, 8'h1, 2'b00, "R4 read allowed");
        do_lookup(20'h1, 8'h1, 2'b01, "R4 write denied");
        chk("R4", "perm fault code", rsp_fault, 2'b10);
        do_lookup(20'h5, 8'h1, 2'b10, "R4 exec allowed");
        do_lookup(20'h5, 8'h1, 2'b11, "R4 code11 as read");
        do_lookup(20'h2, 8'h3, 2'b01, "R5 R2 global full");
        chk("R5", "global full grant pfn", rsp_pfn, 20'hA0002);
        do_lookup(20'h3, 8'h1, 2'b00, "R3 mode 00");
        chk("R3", "domain fault code", rsp_fault, 2'b01);
        do_lookup(20'h4, 8'h1, 2'b10, "R3 mode 11");

        // R2: duplicate match, lowest slot wins (slot 5 holds a second copy of vpn 1).
        do_fill(20'h1, 8'h1, 0, 4'd1, 3'b000, 20'hBBBBB);
        do_lookup(20'h1, 8'h1, 2'b00, "R2 lowest slot");
        chk("R2", "lowest slot pfn", rsp_pfn, 20'hA0001);

        // R6/R12: mode write and lookup in the same cycle see the old mode.
        dmode_we = 1; dmode_wdata = 32'h5555_55C8;
        do_lookup(20'h1, 8'h1, 2'b00, "R12 old mode");
        m_mode = 32'h5555_55C8; dmode_we = 0;
        do_lookup(20'h1, 8'h1, 2'b00, "R6 new mode");
        chk("R6", "new mode denies", rsp_fault, 2'b01);
        do_mode(32'h5555_55C9);

        // R10: page flush clears both copies of vpn 1, keeps others.
        do_flush(0, 1, 20'h1);
        do_lookup(20'h1, 8'h1, 2'b00, "R10 flushed");
        chk("R10", "flushed vpn misses", rsp_miss, 1'b1);
        do_lookup(20'h2, 8'h1, 2'b00, "R10 kept");
        chk("R10", "other vpn kept", rsp_hit, 1'b1);

        // R9: flush all.
        do_flush(1, 0, 20'h0);
        do_lookup(20'h2, 8'h7, 2'b00, "R9 flush all");
        chk("R9", "all flushed", rsp_miss, 1'b1);

        // R8: 17 fills; the oldest is replaced.
        for (int k = 0; k <= N; k++) do_fill(20'h100 + 20'(k), 8'h0, 0, 4'd1, 3'b000, 20'h300 + 20'(k));
        do_lookup(20'h100, 8'h0, 2'b00, "R8 oldest evicted");
        chk("R8", "oldest gone", rsp_miss, 1'b1);
        do_lookup(20'h101, 8'h0, 2'b00, "R8 second kept");
        do_lookup(20'h110, 8'h0, 2'b00, "R8 newest");
        chk("R8", "newest pfn", rsp_pfn, 20'h310);

        // R12: fill and lookup together; the lookup misses, and hits one cycle later.
        begin
            bit eh, ea; logic [1:0] ef; logic [19:0] ep;
            lk_valid = 1; lk_vpn = 20'h777; lk_asid = 0; lk_acc = 0;
            m_lookup(20'h777, 8'h0, 2'b00, eh, ea, ef, ep);
            do_fill(20'h777, 8'h0, 0, 4'd1, 3'b000, 20'h777);
            lk_valid = 0;
            check_rsp("R12 fill same cycle", eh, ea, ef, ep);
            do_lookup(20'h777, 8'h0, 2'b00, "R12 fill next cycle");
            chk("R12", "filled hit", rsp_hit, 1'b1);
        end

        // Random mix.
        for (int it = 0; it < 4000; it++) begin
            int r = int'($urandom_range(99));
            logic [19:0] v = 20'($urandom_range(15));
            logic [7:0]  a = 8'($urandom_range(3));
            if (r < 55) do_lookup(v, a, 2'($urandom_range(3)), "R2 R3 R4 R5 random");
            else if (r < 80) do_fill(v, a, 1'($urandom_range(1)), 4'($urandom_range(15)),
                                     3'($urandom_range(7)), 20'($urandom));
            else if (r < 86) do_flush(0, 1, v);
            else if (r < 87) do_flush(1, 0, 20'h0);
            else do_mode($urandom);
        end
        finish_run();
    end
endmodule